// File: doc/BRIEF.md
# Frame Sync Confirmation and Stuff-Code Monitor

This block follows a parallel frame-sync search stage in a time-division demultiplexer. On each word it may take one overhead bit, together with the word's index in the minor frame. It compares that bit against three 23-bit reference stuff-command patterns (A, B and C) and keeps one saturating 3-bit error counter for each pattern. For word w in 1..23, the matching reference bit is bit w-1 of each pattern.

After the search stage pulses `sync_found`, the block enters confirmation. Only the counter for the pattern chosen by `code_sel` counts, and only over words 12 to 23. At word 24 it either asks the search stage to restart or arms itself. If armed, it declares frame sync at word 28. Once locked, all three counters run over words 1 to 23. At word 24 of every frame the block reports which pattern is present.

The controller has five states. IDLE waits for the search stage. CONFIRM counts the selected pattern. ARMED waits for word 28. LOCKED is maintenance. RESTART is a single cycle that drives the restart pulse. The transitions are:
- IDLE→CONFIRM and RESTART→CONFIRM on `sync_found`.
- RESTART→IDLE otherwise.
- CONFIRM→RESTART at word 24 with too many errors, and CONFIRM→ARMED at word 24 otherwise.
- CONFIRM→CONFIRM and ARMED→CONFIRM on `sync_found`.
- ARMED→LOCKED at word 28.
- LOCKED→LOCKED always.

Top module: `fsync_confirm`

## Requirements
- R1: After reset, `frame_sync`, `search_restart`, `code_valid` and `code_ambig` are low and `code_hit` is zero.
- R2: A word is taken only in a cycle where `word_strobe` and `scan_end` are both high. A bit offered with only one of them high has no effect.
- R3: A `sync_found` pulse outside LOCKED clears all three counters and arms one of them: `code_sel` 0 selects A, 1 selects B, and 2 or 3 select C. Only the armed counter counts during confirmation.
- R4: During confirmation, mismatches are counted only for words 12 to 23. Word w is compared with reference bit w-1.
- R5: If the armed counter holds 3 or more when word 24 is processed, `search_restart` is high for exactly one cycle and `frame_sync` stays low.
- R6: With 2 or fewer errors, `frame_sync` rises when word 28 is processed and stays high until reset. While it is high, `sync_found` is ignored.
- R7: Each counter stops at 7 and does not wrap. Eight errors therefore still count as failing.
- R8: All three counters are cleared when word 29 is processed.
- R9: While locked, each counter counts mismatches between the incoming bit and its own pattern over words 1 to 23.
- R10: While locked, processing word 24 pulses `code_valid` for one cycle. At the same time `code_hit` is loaded with one bit per counter whose count is 2 or less (bit 0 = A, bit 1 = B, bit 2 = C) and is held until the next report. `code_ambig` is set when the number of such bits is not exactly one.
- R11: If `sync_found` arrives in the same cycle that word 24 is processed in CONFIRM, it takes priority. The counters are cleared, no restart pulse is produced, and confirmation stays active.
- R12: Every output change caused by a word appears on the second rising clock edge after the cycle in which that word was offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_strobe | input | 1 | Word timing qualifier |
| scan_end | input | 1 | End-of-scan qualifier |
| ovh_bit | input | 1 | Overhead bit of the current word |
| word_idx | input | WORD_W | Index of the current word in the minor frame |
| sync_found | input | 1 | Pulse from the search stage: candidate alignment found |
| code_sel | input | 2 | Pattern to confirm against (0 A, 1 B, 2/3 C) |
| ref_code_a | input | CODE_LEN | Reference pattern A, bit w-1 for word w |
| ref_code_b | input | CODE_LEN | Reference pattern B |
| ref_code_c | input | CODE_LEN | Reference pattern C |
| frame_sync | output | 1 | Frame sync declared |
| search_restart | output | 1 | One-cycle request to restart the search |
| code_valid | output | 1 | One-cycle pulse: a new pattern report is available |
| code_hit | output | 3 | Patterns whose count is within the limit |
| code_ambig | output | 1 | Zero, or more than one, pattern qualified |

## Verification
The restart decision at word 24 and a fresh `sync_found` from the search stage can land on the same clock edge. One rule must then win: either the block requests a new search, or it starts confirming the new candidate. The bench provokes this with an erroneous confirmation frame. It offers word 24, then raises `sync_found` in the very next cycle, which is the cycle in which word 24 is processed. It then judges the outcome from `search_restart`, which must stay low, and from `frame_sync`, which must stay low at word 28. A following clean frame must still reach lock.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    localparam int NUM_CODES = 3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CONFIRM,
        S_ARMED,
        S_LOCKED,
        S_RESTART
    } fsc_state_e;

endpackage

// File: rtl/fsc_err_cnt.sv
module fsc_err_cnt #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && (cnt != CNT_MAX)) begin
            cnt <= cnt + CNT_ONE;
        end
    end

    // R7: a full counter never wraps
    a_r7_saturate : assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

    // R7: below the ceiling each mismatch adds exactly one
    a_r7_step : assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc && cnt != CNT_MAX) |=> (cnt == $past(cnt) + CNT_ONE));

endmodule

// File: rtl/fsc_ctrl.sv
module fsc_ctrl
    import fsc_pkg::*;
#(
    parameter int WORD_W       = 5,
    parameter int DECIDE_WORD  = 24,
    parameter int DECLARE_WORD = 28
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sync_found,
    input  logic [1:0]           code_sel,
    input  logic                 samp_vld,
    input  logic [WORD_W-1:0]    samp_word,
    input  logic [NUM_CODES-1:0] cnt_over,
    output logic                 confirm_act,
    output logic                 lock_act,
    output logic [NUM_CODES-1:0] arm_oh,
    output logic                 frame_sync,
    output logic                 search_restart
);

    localparam logic [WORD_W-1:0] DECIDE_W  = WORD_W'(DECIDE_WORD);
    localparam logic [WORD_W-1:0] DECLARE_W = WORD_W'(DECLARE_WORD);

    fsc_state_e           state_q, state_d;
    logic [NUM_CODES-1:0] sel_oh_q;
    logic                 at_decide, at_declare, sel_failed;

    function automatic logic [NUM_CODES-1:0] sel_decode(input logic [1:0] s);
        case (s)
            2'd0:    sel_decode = 3'b001;
            2'd1:    sel_decode = 3'b010;
            default: sel_decode = 3'b100;
        endcase
    endfunction

    assign at_decide  = samp_vld && (samp_word == DECIDE_W);
    assign at_declare = samp_vld && (samp_word == DECLARE_W);
    assign sel_failed = |(cnt_over & sel_oh_q);

    // state register (with the latched pattern choice)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            sel_oh_q <= 3'b001;
        end else begin
            state_q <= state_d;
            if (sync_found && (state_q != S_LOCKED)) begin
                sel_oh_q <= sel_decode(code_sel);
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE, S_RESTART: begin
                state_d = sync_found ? S_CONFIRM : S_IDLE;
            end
            S_CONFIRM: begin
                if (sync_found) begin
                    state_d = S_CONFIRM;
                end else if (at_decide) begin
                    state_d = sel_failed ? S_RESTART : S_ARMED;
                end
            end
            S_ARMED: begin
                if (sync_found) begin
                    state_d = S_CONFIRM;
                end else if (at_declare) begin
                    state_d = S_LOCKED;
                end
            end
            S_LOCKED: begin
                state_d = S_LOCKED;
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        confirm_act    = (state_q == S_CONFIRM);
        lock_act       = (state_q == S_LOCKED);
        frame_sync     = (state_q == S_LOCKED);
        search_restart = (state_q == S_RESTART);
        arm_oh         = sel_oh_q;
    end

    // R5: the restart request lasts one cycle
    a_r5_restart_one_cycle : assert property (@(posedge clk) disable iff (!rst_n)
        search_restart |=> !search_restart);

    // R5: a restart never coexists with sync
    a_r5_restart_no_sync : assert property (@(posedge clk) disable iff (!rst_n)
        search_restart |-> !frame_sync);

    // R6: sync is sticky
    a_r6_sync_sticky : assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> frame_sync);

    // R11: a fresh candidate keeps confirmation running
    a_r11_candidate_wins : assert property (@(posedge clk) disable iff (!rst_n)
        (confirm_act && sync_found) |=> (confirm_act && !search_restart));

    // R3: exactly one pattern is armed
    a_r3_single_arm : assert property (@(posedge clk) disable iff (!rst_n)
        confirm_act |-> ($countones(arm_oh) == 1));

endmodule

// File: rtl/fsc_code_report.sv
module fsc_code_report
    import fsc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 report,
    input  logic [NUM_CODES-1:0] cnt_ok,
    output logic                 code_valid,
    output logic [NUM_CODES-1:0] code_hit,
    output logic                 code_ambig
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_valid <= 1'b0;
            code_hit   <= '0;
            code_ambig <= 1'b0;
        end else begin
            code_valid <= report;
            if (report) begin
                code_hit   <= cnt_ok;
                code_ambig <= ($countones(cnt_ok) != 1);
            end
        end
    end

    // R10: an unambiguous report names exactly one pattern
    a_r10_single_hit : assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && !code_ambig) |-> ($countones(code_hit) == 1));

    // R10: the report is held between updates
    a_r10_hold : assert property (@(posedge clk) disable iff (!rst_n)
        !report |=> $stable(code_hit));

endmodule

// File: rtl/fsync_confirm.sv
module fsync_confirm
    import fsc_pkg::*;
#(
    parameter int WORD_W       = 5,
    parameter int CODE_LEN     = 23,
    parameter int CNT_W        = 3,
    parameter int ACQ_FIRST    = 12,
    parameter int ACQ_LAST     = 23,
    parameter int MAINT_FIRST  = 1,
    parameter int MAINT_LAST   = 23,
    parameter int DECIDE_WORD  = 24,
    parameter int DECLARE_WORD = 28,
    parameter int CLEAR_WORD   = 29,
    parameter int ACQ_LIMIT    = 3,
    parameter int MAINT_LIMIT  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                word_strobe,
    input  logic                scan_end,
    input  logic                ovh_bit,
    input  logic [WORD_W-1:0]   word_idx,
    input  logic                sync_found,
    input  logic [1:0]          code_sel,
    input  logic [CODE_LEN-1:0] ref_code_a,
    input  logic [CODE_LEN-1:0] ref_code_b,
    input  logic [CODE_LEN-1:0] ref_code_c,
    output logic                frame_sync,
    output logic                search_restart,
    output logic                code_valid,
    output logic [2:0]          code_hit,
    output logic                code_ambig
);

    localparam logic [WORD_W-1:0] ACQ_FIRST_W   = WORD_W'(ACQ_FIRST);
    localparam logic [WORD_W-1:0] ACQ_LAST_W    = WORD_W'(ACQ_LAST);
    localparam logic [WORD_W-1:0] MAINT_FIRST_W = WORD_W'(MAINT_FIRST);
    localparam logic [WORD_W-1:0] MAINT_LAST_W  = WORD_W'(MAINT_LAST);
    localparam logic [WORD_W-1:0] DECIDE_W      = WORD_W'(DECIDE_WORD);
    localparam logic [WORD_W-1:0] CLEAR_W       = WORD_W'(CLEAR_WORD);
    localparam logic [WORD_W-1:0] WORD_ONE      = WORD_W'(1);
    localparam logic [CNT_W-1:0]  ACQ_LIM_C     = CNT_W'(ACQ_LIMIT);
    localparam logic [CNT_W-1:0]  MAINT_LIM_C   = CNT_W'(MAINT_LIMIT);

    // data-in stage
    logic              samp_vld, samp_bit;
    logic [WORD_W-1:0] samp_word;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_vld  <= 1'b0;
            samp_bit  <= 1'b0;
            samp_word <= '0;
        end else begin
            samp_vld <= word_strobe && scan_end;
            if (word_strobe && scan_end) begin
                samp_bit  <= ovh_bit;
                samp_word <= word_idx;
            end
        end
    end

    logic [NUM_CODES-1:0][CODE_LEN-1:0] refs;
    logic [NUM_CODES-1:0][CNT_W-1:0]    cnt_v;
    logic [NUM_CODES-1:0] arm_oh, cnt_over, cnt_ok, cnt_inc;
    logic [WORD_W-1:0]    bit_idx;
    logic in_acq, in_maint, clr_all, confirm_act, lock_act, report;

    assign refs[0] = ref_code_a;
    assign refs[1] = ref_code_b;
    assign refs[2] = ref_code_c;

    assign bit_idx  = samp_word - WORD_ONE;
    assign in_acq   = samp_vld && (samp_word >= ACQ_FIRST_W) && (samp_word <= ACQ_LAST_W);
    assign in_maint = samp_vld && (samp_word >= MAINT_FIRST_W) && (samp_word <= MAINT_LAST_W);
    assign clr_all  = (sync_found && !lock_act) || (samp_vld && (samp_word == CLEAR_W));
    assign report   = lock_act && samp_vld && (samp_word == DECIDE_W);

    for (genvar i = 0; i < NUM_CODES; i++) begin : g_code
        logic mism;
        assign mism       = samp_bit ^ refs[i][bit_idx];
        assign cnt_inc[i] = mism && ((confirm_act && arm_oh[i] && in_acq) ||
                                     (lock_act && in_maint));
        fsc_err_cnt #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr_all),
            .inc   (cnt_inc[i]),
            .cnt   (cnt_v[i])
        );
        assign cnt_over[i] = (cnt_v[i] >= ACQ_LIM_C);
        assign cnt_ok[i]   = (cnt_v[i] <= MAINT_LIM_C);
    end

    fsc_ctrl #(
        .WORD_W       (WORD_W),
        .DECIDE_WORD  (DECIDE_WORD),
        .DECLARE_WORD (DECLARE_WORD)
    ) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .sync_found     (sync_found),
        .code_sel       (code_sel),
        .samp_vld       (samp_vld),
        .samp_word      (samp_word),
        .cnt_over       (cnt_over),
        .confirm_act    (confirm_act),
        .lock_act       (lock_act),
        .arm_oh         (arm_oh),
        .frame_sync     (frame_sync),
        .search_restart (search_restart)
    );

    fsc_code_report u_report (
        .clk        (clk),
        .rst_n      (rst_n),
        .report     (report),
        .cnt_ok     (cnt_ok),
        .code_valid (code_valid),
        .code_hit   (code_hit),
        .code_ambig (code_ambig)
    );

    // R2: an unqualified cycle produces no sample
    a_r2_qualified_only : assert property (@(posedge clk) disable iff (!rst_n)
        !(word_strobe && scan_end) |=> !samp_vld);

    // R8: counters read zero after the clearing word
    a_r8_clear : assert property (@(posedge clk) disable iff (!rst_n)
        (samp_vld && samp_word == CLEAR_W) |=> (cnt_v == '0));

    // R4: words before the window leave confirmation counts untouched
    a_r4_pre_window : assert property (@(posedge clk) disable iff (!rst_n)
        (confirm_act && !clr_all && samp_vld && samp_word < ACQ_FIRST_W) |=> $stable(cnt_v));

    // R10: reports only come while locked
    a_r10_only_locked : assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |-> frame_sync);

endmodule

// File: tb/fsync_confirm_tb.sv
module fsync_confirm_tb;

    localparam logic [22:0] CODE_B = 23'h1A5C3E;
    localparam logic [22:0] CODE_A = CODE_B ^ 23'h0000FF;
    localparam logic [22:0] CODE_C = CODE_B ^ 23'h7FFF00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_strobe = 1'b0, scan_end = 1'b0, ovh_bit = 1'b0;
    logic [4:0]  word_idx = '0;
    logic        sync_found = 1'b0;
    logic [1:0]  code_sel = 2'd0;
    logic        frame_sync, search_restart, code_valid, code_ambig;
    logic [2:0]  code_hit;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    fsync_confirm u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .word_strobe    (word_strobe),
        .scan_end       (scan_end),
        .ovh_bit        (ovh_bit),
        .word_idx       (word_idx),
        .sync_found     (sync_found),
        .code_sel       (code_sel),
        .ref_code_a     (CODE_A),
        .ref_code_b     (CODE_B),
        .ref_code_c     (CODE_C),
        .frame_sync     (frame_sync),
        .search_restart (search_restart),
        .code_valid     (code_valid),
        .code_hit       (code_hit),
        .code_ambig     (code_ambig)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        word_strobe = 1'b0; scan_end = 1'b0; sync_found = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // one word per two cycles; returns on the negedge after the result edge (R12)
    task automatic send_word(input int w, input logic b);
        word_idx = 5'(w); ovh_bit = b; word_strobe = 1'b1; scan_end = 1'b1;
        @(negedge clk);
        word_strobe = 1'b0; scan_end = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_sync(input logic [1:0] sel);
        code_sel = sel; sync_found = 1'b1;
        @(negedge clk);
        sync_found = 1'b0;
    endtask

    function automatic logic frame_bit(input logic [22:0] code, input logic [31:0] err, input int w);
        if (w >= 1 && w <= 23) return code[w-1] ^ err[w];
        return err[w];
    endfunction

    // confirmation frame: checks restart at word 24 and sync at words 27/28
    task automatic acq_frame(input string req, input logic [22:0] code, input logic [31:0] err,
                             input logic exp_restart, input logic noisy);
        for (int w = 0; w < 32; w++) begin
            if (noisy && w == 15) begin
                // R2: wrong bit with only one qualifier high
                word_idx = 5'(w); ovh_bit = ~frame_bit(code, err, w);
                word_strobe = 1'b1; scan_end = 1'b0;
                repeat (2) @(negedge clk);
                word_strobe = 1'b0; scan_end = 1'b1;
                @(negedge clk);
                scan_end = 1'b0;
                @(negedge clk);
            end
            send_word(w, frame_bit(code, err, w));
            if (w == 24) chk({req, " restart at word 24"}, 32'(search_restart), 32'(exp_restart));
            if (w == 25) chk("R5 restart lasts one cycle", 32'(search_restart), 32'd0);
            if (w == 27) chk("R6 no sync before word 28", 32'(frame_sync), 32'd0);
            if (w == 28) chk({req, " sync at word 28"}, 32'(frame_sync), 32'(!exp_restart));
        end
    endtask

    // maintenance frame: checks the report at word 24 and its hold at word 25
    task automatic maint_frame(input string req, input logic [22:0] code, input logic [31:0] err,
                               input logic [2:0] exp_hit, input logic exp_ambig);
        for (int w = 0; w < 32; w++) begin
            send_word(w, frame_bit(code, err, w));
            if (w == 24) begin
                chk("R10 report pulse", 32'(code_valid), 32'd1);
                chk({req, " code_hit"}, 32'(code_hit), 32'(exp_hit));
                chk({req, " code_ambig"}, 32'(code_ambig), 32'(exp_ambig));
            end
            if (w == 25) begin
                chk("R10 pulse ends", 32'(code_valid), 32'd0);
                chk("R10 hit held", 32'(code_hit), 32'(exp_hit));
            end
        end
        chk("R6 sync stays", 32'(frame_sync), 32'd1);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 frame_sync", 32'(frame_sync), 32'd0);
        chk("R1 search_restart", 32'(search_restart), 32'd0);
        chk("R1 code_valid", 32'(code_valid), 32'd0);
        chk("R1 code_hit", 32'(code_hit), 32'd0);
        chk("R1 code_ambig", 32'(code_ambig), 32'd0);
    endtask

    task automatic t_clean_then_maintain();
        do_reset();
        pulse_sync(2'd1);
        acq_frame("R5 R6 zero errors", CODE_B, 32'h0, 1'b0, 1'b0);
        pulse_sync(2'd2);                         // R6: ignored while locked
        maint_frame("R7 R9 exact B", CODE_B, 32'h0, 3'b010, 1'b0);
        maint_frame("R9 B two errors", CODE_B, 32'h0000_0600, 3'b010, 1'b0);
        maint_frame("R8 cleared each frame", CODE_B, 32'h0000_0600, 3'b010, 1'b0);
        maint_frame("R9 exact A", CODE_A, 32'h0, 3'b001, 1'b0);
        maint_frame("R10 none qualifies", CODE_B, 32'h0000_001E, 3'b000, 1'b1);
    endtask

    task automatic t_two_errors_gated();
        do_reset();
        pulse_sync(2'd1);
        acq_frame("R2 R4 two errors", CODE_B, (32'd1 << 13) | (32'd1 << 20), 1'b0, 1'b1);
    endtask

    task automatic t_three_errors();
        do_reset();
        pulse_sync(2'd1);
        acq_frame("R5 three errors", CODE_B, (32'd1 << 12) | (32'd1 << 17) | (32'd1 << 23), 1'b1, 1'b0);
    endtask

    task automatic t_eight_errors();
        do_reset();
        pulse_sync(2'd1);
        acq_frame("R7 eight errors", CODE_B, 32'h000F_F000, 1'b1, 1'b0);
    endtask

    task automatic t_out_of_window();
        do_reset();
        pulse_sync(2'd1);
        acq_frame("R4 errors outside window", CODE_B, 32'h0400_003E, 1'b0, 1'b0);
    endtask

    task automatic t_select();
        do_reset();
        pulse_sync(2'd2);
        acq_frame("R3 pattern C armed", CODE_B, 32'h0, 1'b1, 1'b0);
        do_reset();
        pulse_sync(2'd0);
        acq_frame("R3 pattern A armed", CODE_A, 32'h0, 1'b0, 1'b0);
    endtask

    task automatic t_coincident();
        logic [31:0] err;
        err = 32'h0001_F000;                      // five errors, words 12..16
        do_reset();
        pulse_sync(2'd1);
        for (int w = 0; w < 32; w++) begin
            if (w == 24) begin
                word_idx = 5'(w); ovh_bit = frame_bit(CODE_B, err, w);
                word_strobe = 1'b1; scan_end = 1'b1;
                @(negedge clk);
                word_strobe = 1'b0; scan_end = 1'b0; sync_found = 1'b1;
                @(negedge clk);
                sync_found = 1'b0;
                chk("R11 no restart on coincident candidate", 32'(search_restart), 32'd0);
            end else begin
                send_word(w, frame_bit(CODE_B, err, w));
            end
            if (w == 28) chk("R11 no sync in that frame", 32'(frame_sync), 32'd0);
        end
        acq_frame("R11 following clean frame", CODE_B, 32'h0, 1'b0, 1'b0);
    endtask

    initial begin : watchdog
        #1_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        t_reset();
        t_clean_then_maintain();
        t_two_errors_gated();
        t_three_errors();
        t_eight_errors();
        t_out_of_window();
        t_select();
        t_coincident();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule